// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block is a small fully associative cache of finished page-table walk results. Each slot holds a virtual page tag, a physical frame, a mapping size (4 KB page, 2 MB block or 1 GB block), a set of attribute bits, a 16-bit address-space identifier and a global flag. The lookup port takes a virtual address and the current address-space identifier. It returns hit or miss, the composed physical address and the attributes one clock later.

A walker writes finished walks through the fill port. It supplies the descriptor's not-global bit, and that bit decides whether the slot is tagged with the supplied identifier or marked global. A maintenance port removes entries in a single cycle using one of six operations. The operations select by page, by identifier, by page across all identifiers, by leaf-only page, or all entries. The operand packs the page number and the identifier into one 64-bit word. When slots run out, a fill replaces entries in round-robin order.

Top module: `asid_tlb`

## Requirements
- R1: A lookup presented in one cycle reports its result after the next rising clock edge. It hits when a valid slot's page matches and the slot is either global or its identifier equals `lk_asid`. When several slots hit, the lowest-numbered slot supplies the result.
- R2: A fill with `fill_ng`=1 (descriptor bit 11 set) tags the slot with `fill_asid`. A fill with `fill_ng`=0 stores the slot as global, and it then hits for any identifier.
- R3: Page comparison and address composition follow the slot's size code `fill_size` (0 = 4 KB, 1 = 2 MB, 2 = 1 GB). The size code selects which VA bits are compared: VA[47:12], VA[47:21] or VA[47:30]. The returned address takes its frame bits from the slot and its lower bits from the lookup VA.
- R4: Operation 0 (by page and identifier) removes non-global slots whose page and identifier both match. It also removes global slots whose page matches. Non-global slots with another identifier stay.
- R5: Operation 2 (by identifier) removes every non-global slot carrying the operand identifier and never removes a global slot.
- R6: Operation 3 (by page, every identifier) removes every slot whose page matches, whatever its identifier or global flag.
- R7: Operations 1 and 4 are the leaf-only forms of operations 0 and 3. They remove only matching slots of size 4 KB and keep matching 2 MB and 1 GB slots.
- R8: Operation 5 removes every slot, and no lookup issued after it hits.
- R9: The operand carries VA[47:12] in bits [35:0] and the identifier in bits [63:48]. Bits [47:36] are ignored.
- R10: A fill goes into the lowest-numbered invalid slot. When every slot is valid, it replaces a round-robin victim that starts at slot 0 after reset and advances by one on each replacement.
- R11: A maintenance operation and a fill in the same cycle: the operation is performed and the fill is dropped.
- R12: Reset empties every slot and clears the lookup outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_va | input | 48 | Lookup virtual address |
| lk_asid | input | 16 | Current address-space identifier for lookup |
| lk_hit | output | 1 | Registered hit flag |
| lk_pa | output | 48 | Registered physical address on hit |
| lk_attr | output | 8 | Registered attributes on hit |
| fill_en | input | 1 | Write a walk result |
| fill_va | input | 48 | Virtual address of the walk |
| fill_pa | input | 48 | Output address of the leaf (frame bits used) |
| fill_size | input | 2 | Mapping size code |
| fill_ng | input | 1 | Descriptor not-global bit |
| fill_asid | input | 16 | Identifier active during the walk |
| fill_attr | input | 8 | Attribute bits of the leaf |
| inv_en | input | 1 | Perform a maintenance operation |
| inv_op | input | 3 | Maintenance operation code |
| inv_operand | input | 64 | Page number and identifier operand |

## Verification
A corrupted tag, identifier or global flag shows up as a wrong hit or a wrong miss on the lookup port two cycles after the fill or operation that caused it. The bench probes the affected page under the owning identifier and under a foreign one. Wrong size handling shows up as the wrong frame bits in `lk_pa` at block boundaries. A wrong victim choice stays hidden until the cache is full. It then shows up as a surviving page that should have been evicted, or as the loss of a page that should have stayed. The bench therefore fills every slot and checks which pages remain after each replacement.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 48;
    localparam int PA_W   = VA_W;
    localparam int PG_SH  = 12;
    localparam int LVL_W  = 9;
    localparam int VPN_W  = VA_W - PG_SH;
    localparam int ASID_W = 16;
    localparam int ATTR_W = 8;
    localparam int OP_W   = 64;
    localparam int OP_ASID_LSB = OP_W - ASID_W;

    typedef enum logic [1:0] {
        SZ_4K = 2'd0,
        SZ_2M = 2'd1,
        SZ_1G = 2'd2
    } map_size_e;

    typedef enum logic [2:0] {
        INV_VA_ASID      = 3'd0,
        INV_VA_ASID_LEAF = 3'd1,
        INV_ASID         = 3'd2,
        INV_VA_ALL       = 3'd3,
        INV_VA_ALL_LEAF  = 3'd4,
        INV_ALL          = 3'd5
    } inv_op_e;

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        map_size_e         size;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    // Page-number bits that take part in a compare for a given size.
    function automatic logic [VPN_W-1:0] size_mask(map_size_e s);
        case (s)
            SZ_2M:   return {{(VPN_W-LVL_W){1'b1}}, {LVL_W{1'b0}}};
            SZ_1G:   return {{(VPN_W-2*LVL_W){1'b1}}, {(2*LVL_W){1'b0}}};
            default: return {VPN_W{1'b1}};
        endcase
    endfunction

    function automatic logic page_eq(logic [VPN_W-1:0] a, logic [VPN_W-1:0] b,
                                     map_size_e s);
        return ((a ^ b) & size_mask(s)) == '0;
    endfunction

    function automatic logic [PA_W-1:0] compose_pa(logic [VPN_W-1:0] ppn,
                                                   logic [VA_W-1:0] va,
                                                   map_size_e s);
        logic [VPN_W-1:0] m;
        m = size_mask(s);
        return {(ppn & m) | (va[VA_W-1:PG_SH] & ~m), va[PG_SH-1:0]};
    endfunction
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
    import tlb_pkg::*;
(
    input  tlb_entry_t        ent,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN_W-1:0]  op_vpn,
    input  logic [ASID_W-1:0] op_asid,
    input  inv_op_e           op,
    output logic              lk_match,
    output logic              inv_match
);
    logic pg_lk, pg_op, leaf, asid_op, kill;

    always_comb begin
        pg_lk   = page_eq(ent.vpn, lk_vpn, ent.size);
        pg_op   = page_eq(ent.vpn, op_vpn, ent.size);
        leaf    = (ent.size == SZ_4K);
        asid_op = ent.glob || (ent.asid == op_asid);
        lk_match = ent.valid && pg_lk && (ent.glob || (ent.asid == lk_asid));
        case (op)
            INV_VA_ASID:      kill = pg_op && asid_op;
            INV_VA_ASID_LEAF: kill = pg_op && asid_op && leaf;
            INV_ASID:         kill = !ent.glob && (ent.asid == op_asid);
            INV_VA_ALL:       kill = pg_op;
            INV_VA_ALL_LEAF:  kill = pg_op && leaf;
            INV_ALL:          kill = 1'b1;
            default:          kill = 1'b0;
        endcase
        inv_match = ent.valid && kill;
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  logic               take,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        any_free = ~&valid;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
        victim = any_free ? free_idx : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (take && !any_free) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              fill_en,
    input  logic [VA_W-1:0]   fill_va,
    input  logic [PA_W-1:0]   fill_pa,
    input  logic [1:0]        fill_size,
    input  logic              fill_ng,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic              inv_en,
    input  logic [2:0]        inv_op,
    input  logic [OP_W-1:0]   inv_operand
);
    tlb_entry_t         ent_q [ENTRIES];
    logic [ENTRIES-1:0] lk_match, inv_match, ent_valid, ent_glob;
    logic [IDX_W-1:0]   sel_idx, vic_idx;
    logic               do_fill;
    logic               unused_bits;

    assign unused_bits = ^{inv_operand[OP_ASID_LSB-1:VPN_W], fill_pa[PG_SH-1:0],
                           fill_va[PG_SH-1:0]};
    assign do_fill = fill_en && !inv_en;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlb_entry_cmp u_cmp (
            .ent      (ent_q[g]),
            .lk_vpn   (lk_va[VA_W-1:PG_SH]),
            .lk_asid  (lk_asid),
            .op_vpn   (inv_operand[VPN_W-1:0]),
            .op_asid  (inv_operand[OP_W-1:OP_ASID_LSB]),
            .op       (inv_op_e'(inv_op)),
            .lk_match (lk_match[g]),
            .inv_match(inv_match[g])
        );
        assign ent_valid[g] = ent_q[g].valid;
        assign ent_glob[g]  = ent_q[g].glob;
    end

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk   (clk),
        .rst   (rst),
        .valid (ent_valid),
        .take  (do_fill),
        .victim(vic_idx)
    );

    always_comb begin
        sel_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) sel_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_hit  <= 1'b0;
            lk_pa   <= '0;
            lk_attr <= '0;
        end else begin
            lk_hit  <= |lk_match;
            lk_pa   <= compose_pa(ent_q[sel_idx].ppn, lk_va, ent_q[sel_idx].size);
            lk_attr <= ent_q[sel_idx].attr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else if (inv_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_match[i]) ent_q[i].valid <= 1'b0;
            end
        end else if (do_fill) begin
            ent_q[vic_idx] <= '{valid: 1'b1,
                                glob:  !fill_ng,
                                asid:  fill_ng ? fill_asid : '0,
                                vpn:   fill_va[VA_W-1:PG_SH],
                                ppn:   fill_pa[PA_W-1:PG_SH],
                                size:  map_size_e'(fill_size),
                                attr:  fill_attr};
        end
    end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk
    import tlb_pkg::*;
#(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         inv_en,
    input logic [2:0]   inv_op,
    input logic         fill_en,
    input logic         lk_hit,
    input logic [N-1:0] ent_valid,
    input logic [N-1:0] ent_glob
);
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (inv_en && inv_op == INV_ALL) |=> (ent_valid == '0));

    assert_no_hit_after_flush_R8: assert property (@(posedge clk) disable iff (rst)
        (inv_en && inv_op == INV_ALL) |=> ##1 !lk_hit);

    assert_asid_spares_global_R5: assert property (@(posedge clk) disable iff (rst)
        (inv_en && inv_op == INV_ASID) |=> ((ent_valid & ent_glob) == $past(ent_valid & ent_glob)));

    assert_fill_uses_free_slot_R10: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !inv_en && !(&ent_valid))
        |=> ($countones(ent_valid) == $past($countones(ent_valid)) + 1));

    assert_inval_beats_fill_R11: assert property (@(posedge clk) disable iff (rst)
        (inv_en && fill_en) |=> ($countones(ent_valid) <= $past($countones(ent_valid))));
endmodule

bind asid_tlb asid_tlb_chk #(.N(ENTRIES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .inv_en   (inv_en),
    .inv_op   (inv_op),
    .fill_en  (fill_en),
    .lk_hit   (lk_hit),
    .ent_valid(ent_valid),
    .ent_glob (ent_glob)
);

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb;
    import tlb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [VA_W-1:0]   lk_va = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic              lk_hit;
    logic [PA_W-1:0]   lk_pa;
    logic [ATTR_W-1:0] lk_attr;
    logic              fill_en = 1'b0;
    logic [VA_W-1:0]   fill_va = '0;
    logic [PA_W-1:0]   fill_pa = '0;
    logic [1:0]        fill_size = '0;
    logic              fill_ng = 1'b0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [ATTR_W-1:0] fill_attr = '0;
    logic              inv_en = 1'b0;
    logic [2:0]        inv_op = '0;
    logic [OP_W-1:0]   inv_operand = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          cyc;
        logic        hit;
        logic [47:0] pa;
        logic [7:0]  attr;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    asid_tlb u_dut (.*);

    // Monitor: compare each queued expectation once its edge has passed.
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (e.hit) begin
                if (!(lk_hit && lk_pa == e.pa && lk_attr == e.attr)) begin
                    errors++;
                    $display("FAIL %s: hit=%0b pa=%h attr=%h expected hit=1 pa=%h attr=%h",
                             e.tag, lk_hit, lk_pa, lk_attr, e.pa, e.attr);
                end
            end else if (lk_hit) begin
                errors++;
                $display("FAIL %s: hit=1 pa=%h expected hit=0", e.tag, lk_pa);
            end
        end
    end

    function automatic logic [63:0] mk_op(logic [47:0] va, logic [15:0] asid);
        return {asid, 12'hA5C, va[47:12]};  // R9: junk in [47:36]
    endfunction

    task automatic lookup(logic [47:0] va, logic [15:0] asid, logic hit,
                          logic [47:0] pa, logic [7:0] attr, string tag);
        @(negedge clk);
        lk_va = va;
        lk_asid = asid;
        sb_q.push_back('{cyc, hit, pa, attr, tag});
    endtask

    task automatic miss(logic [47:0] va, logic [15:0] asid, string tag);
        lookup(va, asid, 1'b0, '0, '0, tag);
    endtask

    task automatic fill(logic [47:0] va, logic [47:0] pa, logic [1:0] sz,
                        logic ng, logic [15:0] asid, logic [7:0] attr);
        @(negedge clk);
        fill_en = 1'b1; fill_va = va; fill_pa = pa; fill_size = sz;
        fill_ng = ng; fill_asid = asid; fill_attr = attr;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic inval(logic [2:0] op, logic [63:0] operand);
        @(negedge clk);
        inv_en = 1'b1; inv_op = op; inv_operand = operand;
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (lk_hit !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset: lk_hit=%b expected 0", lk_hit);
        end
        rst = 1'b0;
        miss(48'h0000_0000_1000, 16'd1, "R12 empty after reset");

        // R1/R2: non-global 4K page
        fill(48'h0000_1234_5000, 48'h0000_ABCD_E000, 2'd0, 1'b1, 16'd5, 8'h11);
        lookup(48'h0000_1234_50AB, 16'd5, 1'b1, 48'h0000_ABCD_E0AB, 8'h11, "R1 R2 asid match");
        miss(48'h0000_1234_50AB, 16'd6, "R1 other asid misses");

        // R2/R3: global 2M block
        fill(48'h0000_0060_0000, 48'h0000_8020_0000, 2'd1, 1'b0, 16'd5, 8'h22);
        lookup(48'h0000_0060_1234, 16'd9, 1'b1, 48'h0000_8020_1234, 8'h22, "R2 global any asid");
        lookup(48'h0000_007F_FFFF, 16'd9, 1'b1, 48'h0000_803F_FFFF, 8'h22, "R3 2M upper edge");
        miss(48'h0000_0080_0000, 16'd9, "R3 past 2M block");

        // R3: 1G block
        fill(48'h0000_8000_0000, 48'h0000_4000_0000, 2'd2, 1'b1, 16'd7, 8'h33);
        lookup(48'h0000_BFFF_F000, 16'd7, 1'b1, 48'h0000_7FFF_F000, 8'h33, "R3 1G block");

        // R5: by identifier
        inval(3'd2, mk_op(48'h0, 16'd5));
        miss(48'h0000_1234_50AB, 16'd5, "R5 non-global removed");
        lookup(48'h0000_0060_1234, 16'd5, 1'b1, 48'h0000_8020_1234, 8'h22, "R5 global kept");
        lookup(48'h0000_BFFF_F000, 16'd7, 1'b1, 48'h0000_7FFF_F000, 8'h33, "R5 other asid kept");

        // R4/R9: by page and identifier
        fill(48'h0000_1234_5000, 48'h0000_ABCD_E000, 2'd0, 1'b1, 16'd5, 8'h11);
        fill(48'h0000_1234_5000, 48'h0000_1111_1000, 2'd0, 1'b1, 16'd6, 8'h44);
        lookup(48'h0000_1234_50AB, 16'd6, 1'b1, 48'h0000_1111_10AB, 8'h44, "R2 second asid same page");
        inval(3'd0, mk_op(48'h0000_1234_5000, 16'd6));
        lookup(48'h0000_1234_50AB, 16'd5, 1'b1, 48'h0000_ABCD_E0AB, 8'h11, "R4 R9 other asid kept");
        miss(48'h0000_1234_50AB, 16'd6, "R4 R9 matching asid removed");
        inval(3'd0, mk_op(48'h0000_0060_0000, 16'd3));
        miss(48'h0000_0060_1234, 16'd9, "R4 global page match removed");
        lookup(48'h0000_BFFF_F000, 16'd7, 1'b1, 48'h0000_7FFF_F000, 8'h33, "R4 unrelated kept");

        // R7: leaf-only keeps block
        fill(48'h0000_0020_0000, 48'h0000_9000_0000, 2'd1, 1'b1, 16'd2, 8'h55);
        fill(48'h0000_0020_3000, 48'h0000_7777_7000, 2'd0, 1'b1, 16'd2, 8'h66);
        inval(3'd1, mk_op(48'h0000_0020_3000, 16'd2));
        lookup(48'h0000_0020_3010, 16'd2, 1'b1, 48'h0000_9000_3010, 8'h55, "R7 leaf gone block kept");
        fill(48'h0000_0020_3000, 48'h0000_7777_7000, 2'd0, 1'b1, 16'd2, 8'h66);
        inval(3'd4, mk_op(48'h0000_0020_3000, 16'd0));
        lookup(48'h0000_0020_3010, 16'd2, 1'b1, 48'h0000_9000_3010, 8'h55, "R7 all-asid leaf form");

        // R6: by page, every identifier
        inval(3'd3, mk_op(48'h0000_0020_3000, 16'd0));
        miss(48'h0000_0020_3010, 16'd2, "R6 block removed any asid");
        lookup(48'h0000_1234_50AB, 16'd5, 1'b1, 48'h0000_ABCD_E0AB, 8'h11, "R6 other page kept");
        inval(3'd3, mk_op(48'h0000_1234_5000, 16'd0));
        miss(48'h0000_1234_50AB, 16'd5, "R6 page removed");

        // R8/R11: flush with a simultaneous fill
        @(negedge clk);
        inv_en = 1'b1; inv_op = 3'd5; inv_operand = '0;
        fill_en = 1'b1; fill_va = 48'h0000_0055_5000; fill_pa = 48'h0000_2222_2000;
        fill_size = 2'd0; fill_ng = 1'b0; fill_asid = 16'd1; fill_attr = 8'h77;
        @(negedge clk);
        inv_en = 1'b0; fill_en = 1'b0;
        miss(48'h0000_BFFF_F000, 16'd7, "R8 flush removes all");
        miss(48'h0000_0055_5000, 16'd1, "R11 fill dropped");

        // R10: placement and round-robin replacement
        for (int i = 0; i < 8; i++)
            fill(48'(48'h10 + i) << 12, 48'h0000_5000_0000 + (48'(i) << 12), 2'd0, 1'b1, 16'd1, 8'(i));
        for (int i = 0; i < 8; i++)
            lookup(48'(48'h10 + i) << 12, 16'd1, 1'b1, 48'h0000_5000_0000 + (48'(i) << 12),
                   8'(i), "R10 all slots filled");
        fill(48'h0000_0002_0000, 48'h0000_6000_0000, 2'd0, 1'b1, 16'd1, 8'h80);
        miss(48'h0000_0001_0000, 16'd1, "R10 first victim slot 0");
        lookup(48'h0000_0001_1000, 16'd1, 1'b1, 48'h0000_5000_1000, 8'h01, "R10 slot 1 kept");
        lookup(48'h0000_0002_0000, 16'd1, 1'b1, 48'h0000_6000_0000, 8'h80, "R10 new page");
        fill(48'h0000_0002_1000, 48'h0000_6001_0000, 2'd0, 1'b1, 16'd1, 8'h81);
        miss(48'h0000_0001_1000, 16'd1, "R10 second victim slot 1");
        lookup(48'h0000_0001_2000, 16'd1, 1'b1, 48'h0000_5000_2000, 8'h02, "R10 slot 2 kept");
        inval(3'd0, mk_op(48'h0000_0001_3000, 16'd1));
        fill(48'h0000_0003_0000, 48'h0000_6100_0000, 2'd0, 1'b1, 16'd1, 8'h90);
        lookup(48'h0000_0001_2000, 16'd1, 1'b1, 48'h0000_5000_2000, 8'h02, "R10 free slot before victim");
        lookup(48'h0000_0003_0000, 16'd1, 1'b1, 48'h0000_6100_0000, 8'h90, "R10 placed in freed slot");
        miss(48'h0000_0001_3000, 16'd1, "R10 freed page gone");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule